// File: doc/BRIEF.md
# Branch Target Instruction Cache

This block sits next to an instruction prefetch queue and keeps a short run of instructions for each recently taken branch target. When the fetch unit reports a taken branch, the target word address is compared against every general entry in the same cycle. On a hit, the block tells the prefetch queue to restart past the cached run. From the next cycle it streams the stored instructions to the core over a valid/ready port, which hides the latency of the slow program memory. On a miss, the prefetch queue restarts at the target itself. The block claims the least recently used general entry and captures the next run of words that memory returns.

One extra entry is kept only for the fetch that reads the interrupt vector address. Branch misses never evict it. Sequential fetches and data-constant loads at non-sequential addresses leave the cache, the restart request and any transfer in progress untouched. A single invalidate-all input empties every entry after program memory has been rewritten.

Top module: `btarget_cache`

## Requirements
- R1: After reset, `out_valid`, `lk_hit` and `pf_restart_valid` are low and every entry is empty, so the first lookup of any address misses.
- R2: A lookup is a cycle with `req_valid` high and `req_kind` equal to 1 (taken branch) or 2 (vector read). `lk_hit` shows the result in that same cycle. A branch lookup compares `req_addr` against all general entries at once.
- R3: During a lookup, `pf_restart_valid` is high. `pf_restart_addr` equals `req_addr + RUN_LEN` on a hit and `req_addr` on a miss.
- R4: On a hit, starting the cycle after the lookup, the entry's `RUN_LEN` words appear on `out_data` in address order, one per accepted handshake. After the last word `out_valid` goes low.
- R5: On a miss, the block captures the next `RUN_LEN` words presented with `mem_valid` into the chosen entry. A later lookup of the same address hits and returns exactly those words.
- R6: `req_kind` 0 (sequential) and 3 (data-constant load) start no lookup. They raise no restart, change no entry, and do not disturb a stream or a fill in progress.
- R7: A branch miss evicts the general entry whose most recent hit or allocation is oldest.
- R8: A lookup that arrives before a fill completes abandons the fill, and the partly written entry then misses.
- R9: A vector lookup (kind 2) consults and fills only the dedicated entry, and branch misses never replace that entry.
- R10: `flush_all` empties every entry, including the dedicated one. It also ends any stream or fill, with `out_valid` low from the next cycle.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` holds and the stream resumes at the same word.
- R12: A lookup during a stream aborts it. On a hit, the new entry's first word is shown in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_all | input | 1 | Invalidate every entry and stop activity |
| req_valid | input | 1 | Fetch-unit event present |
| req_kind | input | 2 | 0 sequential, 1 taken branch, 2 vector read, 3 data-constant load |
| req_addr | input | ADDR_W | Target word address |
| lk_hit | output | 1 | Lookup hit, same cycle |
| pf_restart_valid | output | 1 | Prefetch queue must restart |
| pf_restart_addr | output | ADDR_W | Word address the prefetch queue restarts at |
| mem_valid | input | 1 | Program-memory word present |
| mem_data | input | INSN_W | Program-memory word |
| out_valid | output | 1 | Cached instruction present |
| out_ready | input | 1 | Core accepts the instruction |
| out_data | output | INSN_W | Cached instruction |

## Verification
The bench builds the block with three general entries, four-word runs and 16-bit addresses and instructions. With only three general entries, the oldest entry is evicted after a handful of branches, so least-recently-used ordering and the protection of the vector entry can both be tested in short scenarios. With four-word runs, a test can stall a stream, abort it, and cut a fill short partway, and still have words left before and after the event.

// File: rtl/btarget_pkg.sv
`timescale 1ns/1ps
package btarget_pkg;
   typedef enum logic [1:0] {
      FK_SEQ     = 2'd0,
      FK_BRANCH  = 2'd1,
      FK_VECTOR  = 2'd2,
      FK_LITERAL = 2'd3
   } fetch_kind_e;
endpackage

// File: rtl/btarget_tagbank.sv
`timescale 1ns/1ps
// Tags and valid flags for all entries; the last entry is the dedicated vector slot.
module btarget_tagbank #(
   parameter int ADDR_W = 32,
   parameter int N_GEN  = 15,
   localparam int N_ENT = N_GEN + 1,
   localparam int ENT_W = $clog2(N_ENT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              alloc_en,
   input  logic [ENT_W-1:0]  alloc_idx,
   input  logic [ADDR_W-1:0] alloc_tag,
   input  logic              fin_en,
   input  logic [ENT_W-1:0]  fin_idx,
   input  logic [ADDR_W-1:0] look_addr,
   output logic [N_GEN-1:0]  gen_hit,
   output logic              vec_hit
);
   logic [N_ENT-1:0] hits;

   for (genvar e = 0; e < N_ENT; e++) begin : g_ent
      logic              vld_q;
      logic [ADDR_W-1:0] tag_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_q <= 1'b0;
            tag_q <= '0;
         end else if (flush) begin
            vld_q <= 1'b0;
         end else if (alloc_en && alloc_idx == ENT_W'(e)) begin
            vld_q <= 1'b0;
            tag_q <= alloc_tag;
         end else if (fin_en && fin_idx == ENT_W'(e)) begin
            vld_q <= 1'b1;
         end
      end

      assign hits[e] = vld_q && (tag_q == look_addr);
   end

   assign gen_hit = hits[N_GEN-1:0];
   assign vec_hit = hits[N_GEN];
endmodule

// File: rtl/btarget_age.sv
`timescale 1ns/1ps
// Age list over the general entries: 0 is newest, N_GEN-1 is the victim.
module btarget_age #(
   parameter int N_GEN = 15,
   localparam int GEN_W = $clog2(N_GEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [GEN_W-1:0] touch_idx,
   output logic [GEN_W-1:0] victim_idx
);
   localparam logic [GEN_W-1:0] OLDEST = GEN_W'(N_GEN - 1);

   logic [GEN_W-1:0] age_q [N_GEN];
   logic [GEN_W-1:0] touched_age;

   assign touched_age = age_q[touch_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N_GEN; i++) age_q[i] <= GEN_W'(i);
      end else if (touch_en) begin
         for (int i = 0; i < N_GEN; i++) begin
            if (GEN_W'(i) == touch_idx)      age_q[i] <= '0;
            else if (age_q[i] < touched_age) age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   always_comb begin
      victim_idx = '0;
      for (int i = 0; i < N_GEN; i++)
         if (age_q[i] == OLDEST) victim_idx = GEN_W'(i);
   end
endmodule

// File: rtl/btarget_store.sv
`timescale 1ns/1ps
// Instruction storage: one run of RUN_LEN words per entry.
module btarget_store #(
   parameter int INSN_W  = 32,
   parameter int N_ENT   = 16,
   parameter int RUN_LEN = 8,
   localparam int ENT_W  = $clog2(N_ENT),
   localparam int WORD_W = $clog2(RUN_LEN),
   localparam int DEPTH  = N_ENT * RUN_LEN
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ENT_W-1:0]  wr_ent,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [INSN_W-1:0] wr_data,
   input  logic [ENT_W-1:0]  rd_ent,
   input  logic [WORD_W-1:0] rd_word,
   output logic [INSN_W-1:0] rd_data
);
   logic [INSN_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[{wr_ent, wr_word}] <= wr_data;
   end

   assign rd_data = mem_q[{rd_ent, rd_word}];
endmodule

// File: rtl/btarget_cache.sv
`timescale 1ns/1ps
module btarget_cache
   import btarget_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int INSN_W  = 32,
   parameter int N_GEN   = 15,
   parameter int RUN_LEN = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush_all,
   input  logic              req_valid,
   input  logic [1:0]        req_kind,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              lk_hit,
   output logic              pf_restart_valid,
   output logic [ADDR_W-1:0] pf_restart_addr,
   input  logic              mem_valid,
   input  logic [INSN_W-1:0] mem_data,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [INSN_W-1:0] out_data
);
   localparam int N_ENT  = N_GEN + 1;
   localparam int ENT_W  = $clog2(N_ENT);
   localparam int GEN_W  = $clog2(N_GEN);
   localparam int WORD_W = $clog2(RUN_LEN);
   localparam logic [ENT_W-1:0]  VEC_ENT   = ENT_W'(N_GEN);
   localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(RUN_LEN - 1);

   // Elaboration-time parameter checks.
   if (N_GEN < 2 || N_GEN > 63) begin : g_bad_n_gen
      $error("btarget_cache: N_GEN must lie in 2..63");
   end
   if (RUN_LEN < 2 || (RUN_LEN & (RUN_LEN - 1)) != 0) begin : g_bad_run_len
      $error("btarget_cache: RUN_LEN must be a power of two, at least 2");
   end
   if (ADDR_W < 4 || INSN_W < 1) begin : g_bad_widths
      $error("btarget_cache: ADDR_W must be at least 4 and INSN_W at least 1");
   end

   // Request decode.
   fetch_kind_e kind;
   logic        is_br, is_vec, is_lk;

   assign kind   = fetch_kind_e'(req_kind);
   assign is_br  = req_valid && (kind == FK_BRANCH);
   assign is_vec = req_valid && (kind == FK_VECTOR);
   assign is_lk  = is_br || is_vec;

   // Lookup.
   logic [N_GEN-1:0] gen_hit;
   logic             vec_hit;
   logic             hit_now;
   logic [GEN_W-1:0] hit_gen_idx;
   logic [GEN_W-1:0] victim_idx;
   logic [ENT_W-1:0] hit_ent;

   assign hit_now = (is_br && (|gen_hit)) || (is_vec && vec_hit);

   always_comb begin
      hit_gen_idx = '0;
      for (int i = 0; i < N_GEN; i++)
         if (gen_hit[i]) hit_gen_idx = GEN_W'(i);
   end

   assign hit_ent = is_vec ? VEC_ENT : ENT_W'(hit_gen_idx);

   // Stream and fill state.
   logic              strm_on_q;
   logic [ENT_W-1:0]  strm_ent_q;
   logic [WORD_W-1:0] strm_idx_q;
   logic              fill_on_q;
   logic [ENT_W-1:0]  fill_ent_q;
   logic [WORD_W-1:0] fill_cnt_q;

   logic              alloc_en;
   logic [ENT_W-1:0]  alloc_idx;
   logic              touch_en;
   logic [GEN_W-1:0]  touch_idx;
   logic              fill_take;
   logic              fin_en;
   logic [INSN_W-1:0] rd_data;

   assign alloc_en  = is_lk && !hit_now && !flush_all;
   assign alloc_idx = is_vec ? VEC_ENT : ENT_W'(victim_idx);
   assign touch_en  = is_br && !flush_all;
   assign touch_idx = hit_now ? hit_gen_idx : victim_idx;
   assign fill_take = fill_on_q && mem_valid && !is_lk && !flush_all;
   assign fin_en    = fill_take && (fill_cnt_q == LAST_WORD);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strm_on_q  <= 1'b0;
         strm_ent_q <= '0;
         strm_idx_q <= '0;
         fill_on_q  <= 1'b0;
         fill_ent_q <= '0;
         fill_cnt_q <= '0;
      end else if (flush_all) begin
         strm_on_q <= 1'b0;
         fill_on_q <= 1'b0;
      end else if (is_lk) begin
         // A new lookup always ends the previous stream or fill.
         strm_on_q  <= hit_now;
         strm_ent_q <= hit_ent;
         strm_idx_q <= '0;
         fill_on_q  <= !hit_now;
         fill_ent_q <= alloc_idx;
         fill_cnt_q <= '0;
      end else begin
         if (strm_on_q && out_ready) begin
            strm_idx_q <= strm_idx_q + 1'b1;
            if (strm_idx_q == LAST_WORD) strm_on_q <= 1'b0;
         end
         if (fill_take) begin
            fill_cnt_q <= fill_cnt_q + 1'b1;
            if (fill_cnt_q == LAST_WORD) fill_on_q <= 1'b0;
         end
      end
   end

   btarget_tagbank #(.ADDR_W(ADDR_W), .N_GEN(N_GEN)) u_tags (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush_all),
      .alloc_en  (alloc_en),
      .alloc_idx (alloc_idx),
      .alloc_tag (req_addr),
      .fin_en    (fin_en),
      .fin_idx   (fill_ent_q),
      .look_addr (req_addr),
      .gen_hit   (gen_hit),
      .vec_hit   (vec_hit)
   );

   btarget_age #(.N_GEN(N_GEN)) u_age (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch_en   (touch_en),
      .touch_idx  (touch_idx),
      .victim_idx (victim_idx)
   );

   btarget_store #(.INSN_W(INSN_W), .N_ENT(N_ENT), .RUN_LEN(RUN_LEN)) u_store (
      .clk     (clk),
      .wr_en   (fill_take),
      .wr_ent  (fill_ent_q),
      .wr_word (fill_cnt_q),
      .wr_data (mem_data),
      .rd_ent  (strm_ent_q),
      .rd_word (strm_idx_q),
      .rd_data (rd_data)
   );

   assign lk_hit           = hit_now;
   assign pf_restart_valid = is_lk;
   assign pf_restart_addr  = hit_now ? (req_addr + ADDR_W'(RUN_LEN)) : req_addr;
   assign out_valid        = strm_on_q;
   assign out_data         = rd_data;
endmodule

// File: rtl/btarget_cache_chk.sv
`timescale 1ns/1ps
module btarget_cache_chk #(
   parameter int ADDR_W  = 32,
   parameter int INSN_W  = 32,
   parameter int RUN_LEN = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              flush_all,
   input logic              req_valid,
   input logic [1:0]        req_kind,
   input logic [ADDR_W-1:0] req_addr,
   input logic              lk_hit,
   input logic              pf_restart_valid,
   input logic [ADDR_W-1:0] pf_restart_addr,
   input logic              out_valid,
   input logic              out_ready,
   input logic [INSN_W-1:0] out_data
);
   logic quiet_kind;
   assign quiet_kind = req_valid && (req_kind == 2'd0 || req_kind == 2'd3);

   always @(posedge clk) begin
      if (rst_n) begin
         assert_hit_needs_req_R2: assert (!lk_hit || req_valid);
      end
   end

   assert_quiet_kinds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      quiet_kind |-> (!pf_restart_valid && !lk_hit));

   assert_hit_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> (pf_restart_valid && pf_restart_addr == req_addr + ADDR_W'(RUN_LEN)));

   assert_hit_streams_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && !flush_all) |=> out_valid);

   assert_miss_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_restart_valid && !lk_hit && !flush_all) |=> !out_valid);

   assert_flush_stops_R10: assert property (@(posedge clk) disable iff (!rst_n)
      flush_all |=> !out_valid);

   assert_stall_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !pf_restart_valid && !flush_all)
      |=> (out_valid && $stable(out_data)));
endmodule

bind btarget_cache btarget_cache_chk #(
   .ADDR_W(ADDR_W), .INSN_W(INSN_W), .RUN_LEN(RUN_LEN)
) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .flush_all        (flush_all),
   .req_valid        (req_valid),
   .req_kind         (req_kind),
   .req_addr         (req_addr),
   .lk_hit           (lk_hit),
   .pf_restart_valid (pf_restart_valid),
   .pf_restart_addr  (pf_restart_addr),
   .out_valid        (out_valid),
   .out_ready        (out_ready),
   .out_data         (out_data)
);

// File: tb/btarget_cache_bench.sv
`timescale 1ns/1ps
module btarget_cache_bench;
   localparam int AW  = 16;
   localparam int IW  = 16;
   localparam int NG  = 3;
   localparam int RL  = 4;

   localparam logic [1:0] K_SEQ = 2'd0, K_BR = 2'd1, K_VEC = 2'd2, K_LIT = 2'd3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          flush_all;
   logic          req_valid;
   logic [1:0]    req_kind;
   logic [AW-1:0] req_addr;
   logic          lk_hit;
   logic          pf_restart_valid;
   logic [AW-1:0] pf_restart_addr;
   logic          mem_valid;
   logic [IW-1:0] mem_data;
   logic          out_valid;
   logic          out_ready;
   logic [IW-1:0] out_data;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   btarget_cache #(.ADDR_W(AW), .INSN_W(IW), .N_GEN(NG), .RUN_LEN(RL)) u_btarget_cache (
      .clk(clk), .rst_n(rst_n), .flush_all(flush_all),
      .req_valid(req_valid), .req_kind(req_kind), .req_addr(req_addr),
      .lk_hit(lk_hit), .pf_restart_valid(pf_restart_valid), .pf_restart_addr(pf_restart_addr),
      .mem_valid(mem_valid), .mem_data(mem_data),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
   );

   function automatic logic [IW-1:0] wd(logic [AW-1:0] a, int i);
      return {4'(i), a[11:0]};
   endfunction

   task automatic check(bit ok, string rq, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   // Presents one request at a negedge, checks the same-cycle outputs,
   // returns at the next negedge with the request removed.
   task automatic lookup(logic [1:0] k, logic [AW-1:0] a, bit exp_hit, string rq);
      bit exp_pv;
      @(negedge clk);
      req_valid = 1'b1; req_kind = k; req_addr = a;
      #1;
      exp_pv = (k == K_BR || k == K_VEC);
      check(lk_hit == exp_hit, rq, "lk_hit", int'(lk_hit), int'(exp_hit));
      check(pf_restart_valid == exp_pv, rq, "pf_restart_valid",
            int'(pf_restart_valid), int'(exp_pv));
      if (exp_pv)
         check(pf_restart_addr == (exp_hit ? a + AW'(RL) : a), rq, "pf_restart_addr",
               int'(pf_restart_addr), int'(exp_hit ? a + AW'(RL) : a));
      @(negedge clk);
      req_valid = 1'b0; req_kind = K_SEQ;
   endtask

   task automatic fill(logic [AW-1:0] a);
      for (int i = 0; i < RL; i++) begin
         mem_valid = 1'b1; mem_data = wd(a, i);
         @(negedge clk);
      end
      mem_valid = 1'b0;
   endtask

   task automatic expect_stream(logic [AW-1:0] a, int from, string rq);
      for (int i = from; i < RL; i++) begin
         #1;
         check(out_valid == 1'b1, rq, "out_valid", int'(out_valid), 1);
         check(out_data == wd(a, i), rq, "out_data", int'(out_data), int'(wd(a, i)));
         @(negedge clk);
      end
      #1;
      check(out_valid == 1'b0, rq, "out_valid after run", int'(out_valid), 0);
   endtask

   task automatic learn(logic [1:0] k, logic [AW-1:0] a, string rq);
      lookup(k, a, 1'b0, rq);
      fill(a);
   endtask

   task automatic hit_run(logic [1:0] k, logic [AW-1:0] a, string rq);
      lookup(k, a, 1'b1, rq);
      expect_stream(a, 0, rq);
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      #1;
      check(out_valid == 1'b0, "R1", "out_valid at reset", int'(out_valid), 0);
      check(lk_hit == 1'b0, "R1", "lk_hit at reset", int'(lk_hit), 0);
      check(pf_restart_valid == 1'b0, "R1", "pf_restart_valid at reset", int'(pf_restart_valid), 0);
      learn(K_BR, 16'h0100, "R1");
   endtask

   task automatic t_hit_stream();
      hit_run(K_BR, 16'h0100, "R4");
      learn(K_BR, 16'h0110, "R5");
      hit_run(K_BR, 16'h0110, "R5");
   endtask

   task automatic t_ignored();
      lookup(K_SEQ, 16'h0100, 1'b0, "R6");
      lookup(K_LIT, 16'h0100, 1'b0, "R6");
      // literal in the middle of a stream
      lookup(K_BR, 16'h0100, 1'b1, "R6");
      #1;
      check(out_data == wd(16'h0100, 0), "R6", "word0", int'(out_data), int'(wd(16'h0100, 0)));
      @(negedge clk);
      req_valid = 1'b1; req_kind = K_LIT; req_addr = 16'h0110;
      #1;
      check(pf_restart_valid == 1'b0, "R6", "literal restart", int'(pf_restart_valid), 0);
      @(negedge clk);
      req_valid = 1'b0; req_kind = K_SEQ;
      expect_stream(16'h0100, 2, "R6");
      // literal in the middle of a fill
      lookup(K_BR, 16'h0120, 1'b0, "R6");
      for (int i = 0; i < RL; i++) begin
         mem_valid = 1'b1; mem_data = wd(16'h0120, i);
         if (i == 1) begin req_valid = 1'b1; req_kind = K_LIT; req_addr = 16'h0120; end
         @(negedge clk);
         req_valid = 1'b0; req_kind = K_SEQ;
      end
      mem_valid = 1'b0;
      hit_run(K_BR, 16'h0120, "R6");
   endtask

   task automatic t_backpressure();
      lookup(K_BR, 16'h0100, 1'b1, "R11");
      out_ready = 1'b0;
      for (int c = 0; c < 3; c++) begin
         #1;
         check(out_valid && out_data == wd(16'h0100, 0), "R11", "held word0",
               int'(out_data), int'(wd(16'h0100, 0)));
         if (c == 2) out_ready = 1'b1;
         @(negedge clk);
      end
      expect_stream(16'h0100, 1, "R11");
   endtask

   task automatic t_abort();
      lookup(K_BR, 16'h0100, 1'b1, "R12");
      #1;
      check(out_data == wd(16'h0100, 0), "R12", "first run word0", int'(out_data), int'(wd(16'h0100, 0)));
      @(negedge clk);
      #1;
      check(out_data == wd(16'h0100, 1), "R12", "first run word1", int'(out_data), int'(wd(16'h0100, 1)));
      lookup(K_BR, 16'h0110, 1'b1, "R12");
      expect_stream(16'h0110, 0, "R12");
   endtask

   task automatic t_partial();
      lookup(K_BR, 16'h0130, 1'b0, "R8");
      for (int i = 0; i < 2; i++) begin
         mem_valid = 1'b1; mem_data = wd(16'h0130, i);
         @(negedge clk);
      end
      mem_valid = 1'b0;
      hit_run(K_BR, 16'h0100, "R8");
      lookup(K_BR, 16'h0130, 1'b0, "R8");
   endtask

   task automatic t_vector();
      learn(K_VEC, 16'h00C0, "R9");
      // the vector address is not visible to branch lookups
      lookup(K_BR, 16'h00C0, 1'b0, "R9");
      for (int g = 0; g < NG + 1; g++) learn(K_BR, 16'h0300 + AW'(g * 16), "R9");
      hit_run(K_VEC, 16'h00C0, "R9");
      hit_run(K_BR, 16'h0330, "R9");
      // a general address is not visible to vector lookups
      lookup(K_VEC, 16'h0330, 1'b0, "R9");
   endtask

   task automatic t_flush();
      learn(K_VEC, 16'h00D0, "R10");
      lookup(K_BR, 16'h0330, 1'b1, "R10");
      flush_all = 1'b1;
      #1;
      check(out_valid == 1'b1, "R10", "stream before flush", int'(out_valid), 1);
      @(negedge clk);
      flush_all = 1'b0;
      #1;
      check(out_valid == 1'b0, "R10", "stream after flush", int'(out_valid), 0);
      lookup(K_BR, 16'h0330, 1'b0, "R10");
      lookup(K_VEC, 16'h00D0, 1'b0, "R10");
   endtask

   task automatic t_lru();
      learn(K_BR, 16'h0200, "R7");
      learn(K_BR, 16'h0210, "R7");
      learn(K_BR, 16'h0220, "R7");
      hit_run(K_BR, 16'h0200, "R7");
      learn(K_BR, 16'h0230, "R7");   // evicts 0x0210
      hit_run(K_BR, 16'h0220, "R7");
      hit_run(K_BR, 16'h0200, "R7");
      hit_run(K_BR, 16'h0230, "R7");
      lookup(K_BR, 16'h0210, 1'b0, "R7");
   endtask

   initial begin
      rst_n = 1'b0; flush_all = 1'b0; req_valid = 1'b0; req_kind = K_SEQ;
      req_addr = '0; mem_valid = 1'b0; mem_data = '0; out_ready = 1'b1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_hit_stream();
      t_ignored();
      t_backpressure();
      t_abort();
      t_partial();
      t_vector();
      t_flush();
      t_lru();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule